// File: doc/BRIEF.md
# Backup Cell Health Latch

This block reports whether the primary backup cell is healthy, weak or exhausted. It drives two active-low indicators: one for a weak cell and one for a dead cell. It reads two inputs. The first is a synchronous supply-valid flag. The second is a digitised voltage code for the primary cell, produced by a converter outside the block.

The cell is judged only once per power-up, on the first clock edge at which the supply flag reads valid after having been invalid. The verdict is stored, but it stays hidden for a programmable number of clock cycles so that the rest of the system can settle. Once shown, the verdict stays frozen for as long as the supply remains valid. Later movement on the voltage code is ignored until the supply drops and comes back.

Both thresholds are parameters, and so is the hiding delay. The default thresholds assume a code step of 20 mV: code 115 stands for 2.3 V (weak) and code 100 stands for 2.0 V (dead). The dead threshold must not exceed the weak threshold.

Top module: `batt_health_latch`

## Requirements
- R1: While reset is held, and right after it is released with the supply flag low, both indicators read 1 (inactive).
- R2: One clock edge after the supply flag is sampled low, both indicators read 1, and they stay at 1 for as long as the flag stays low.
- R3: The verdict comes from the voltage code present at the first clock edge where the supply flag is high following a low sample (the sample edge). A code that changes on the next cycle does not alter the verdict.
- R4: Counting the sample edge as edge 0, both indicators read 1 through edge DELAY_CYC-1. The verdict appears on the indicators from edge DELAY_CYC onward.
- R5: A sampled code greater than or equal to LOW_CODE gives weak = 1 and dead = 1. A code exactly equal to LOW_CODE counts as healthy.
- R6: A sampled code in the range FAIL_CODE ≤ code < LOW_CODE gives weak = 0 and dead = 1. A code exactly equal to FAIL_CODE falls in this range.
- R7: A sampled code below FAIL_CODE gives weak = 0 and dead = 0. The dead indicator never reads 0 while the weak indicator reads 1.
- R8: While the supply flag stays high after the verdict is shown, the indicators do not change, whatever the voltage code does.
- R9: When the supply drops, even for a period shorter than DELAY_CYC, the old verdict is discarded. The next power-up takes a fresh sample and restarts the full delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_ok | input | 1 | Supply-valid flag, synchronous to clk |
| cell_code | input | CODE_W | Digitised primary-cell voltage |
| bat_low_n | output | 1 | Weak-cell indicator, active low |
| bat_fail_n | output | 1 | Dead-cell indicator, active low |

## Verification
The assertions assume that pwr_ok and cell_code are already synchronous to clk. They also assume that reset starts with the supply flag low, or with a defined value on it, so that the first high sample is always seen as a rising transition. The bench changes every input on the falling clock edge only and holds each code steady across the sample edge. It then moves the code deliberately after sampling, both before and after the verdict is revealed, to show that late changes have no effect. Short supply drops are applied between whole clock cycles, so every drop is seen by at least one edge.

// File: rtl/batt_health_pkg.sv
package batt_health_pkg;

    typedef enum logic [1:0] {
        HEALTH_OK   = 2'd0,
        HEALTH_LOW  = 2'd1,
        HEALTH_FAIL = 2'd2
    } health_e;

    typedef struct packed {
        logic weak_n;
        logic dead_n;
    } ind_t;

    localparam ind_t IND_IDLE = '{weak_n: 1'b1, dead_n: 1'b1};

    function automatic health_e classify(input int unsigned code,
                                         input int unsigned low_lim,
                                         input int unsigned fail_lim);
        if (code < fail_lim)     return HEALTH_FAIL;
        else if (code < low_lim) return HEALTH_LOW;
        else                     return HEALTH_OK;
    endfunction

    function automatic ind_t encode(input health_e h);
        ind_t r;
        r.weak_n = (h == HEALTH_OK);
        r.dead_n = (h != HEALTH_FAIL);
        return r;
    endfunction

endpackage

// File: rtl/batt_supply_track.sv
module batt_supply_track (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    output logic pwr_q,
    output logic rise
);
    always_ff @(posedge clk) begin
        if (rst) pwr_q <= 1'b0;
        else     pwr_q <= pwr_ok;
    end

    assign rise = pwr_ok && !pwr_q;

endmodule

// File: rtl/batt_sampler.sv
module batt_sampler
    import batt_health_pkg::*;
#(
    parameter int unsigned CODE_W    = 8,
    parameter int unsigned LOW_CODE  = 115,
    parameter int unsigned FAIL_CODE = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok,
    input  logic              pwr_q,
    input  logic              rise,
    input  logic [CODE_W-1:0] cell_code,
    output health_e           health
);
    always_ff @(posedge clk) begin
        if (rst || !pwr_ok)
            health <= HEALTH_OK;
        else if (rise)
            health <= classify(32'(cell_code), LOW_CODE, FAIL_CODE);
    end

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && pwr_q) |=> $stable(health));

    // R9
    cleared_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_ok |=> (health == HEALTH_OK));

endmodule

// File: rtl/batt_reveal_delay.sv
module batt_reveal_delay #(
    parameter int unsigned DELAY_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_ok,
    input  logic rise,
    output logic done
);
    generate
        if (DELAY_CYC == 0) begin : g_nodelay
            assign done = 1'b1;
        end else begin : g_count
            localparam int unsigned CNT_W = $clog2(DELAY_CYC + 1);
            localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYC);
            logic [CNT_W-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !pwr_ok || rise) cnt <= '0;
                else if (cnt != LAST)       cnt <= cnt + 1'b1;
            end

            assign done = (cnt == LAST);

            // R4
            no_early_chk: assert property (@(posedge clk) disable iff (rst)
                rise |=> !done);

            // R4
            cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
                cnt <= LAST);
        end
    endgenerate

endmodule

// File: rtl/batt_health_latch.sv
module batt_health_latch
    import batt_health_pkg::*;
#(
    parameter int unsigned CODE_W    = 8,
    parameter int unsigned LOW_CODE  = 115,
    parameter int unsigned FAIL_CODE = 100,
    parameter int unsigned DELAY_CYC = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok,
    input  logic [CODE_W-1:0] cell_code,
    output logic              bat_low_n,
    output logic              bat_fail_n
);
    logic    pwr_q;
    logic    rise;
    logic    done;
    health_e health;
    ind_t    ind;

    batt_supply_track u_track (
        .clk    (clk),
        .rst    (rst),
        .pwr_ok (pwr_ok),
        .pwr_q  (pwr_q),
        .rise   (rise)
    );

    batt_sampler #(
        .CODE_W    (CODE_W),
        .LOW_CODE  (LOW_CODE),
        .FAIL_CODE (FAIL_CODE)
    ) u_sampler (
        .clk       (clk),
        .rst       (rst),
        .pwr_ok    (pwr_ok),
        .pwr_q     (pwr_q),
        .rise      (rise),
        .cell_code (cell_code),
        .health    (health)
    );

    batt_reveal_delay #(
        .DELAY_CYC (DELAY_CYC)
    ) u_delay (
        .clk    (clk),
        .rst    (rst),
        .pwr_ok (pwr_ok),
        .rise   (rise),
        .done   (done)
    );

    always_comb begin
        if (pwr_q && done) ind = encode(health);
        else               ind = IND_IDLE;
    end

    assign bat_low_n  = ind.weak_n;
    assign bat_fail_n = ind.dead_n;

    // R2
    idle_high_chk: assert property (@(posedge clk) disable iff (rst)
        !pwr_q |-> (bat_low_n && bat_fail_n));

    // R7
    fail_implies_low_chk: assert property (@(posedge clk) disable iff (rst)
        !bat_fail_n |-> !bat_low_n);

    // R8
    out_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (pwr_ok && pwr_q && done) |=> $stable({bat_low_n, bat_fail_n}));

endmodule

// File: tb/batt_health_latch_tb.sv
module batt_health_latch_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 8;
    localparam int LOW_CODE   = 115;
    localparam int FAIL_CODE  = 100;
    localparam int DELAY_CYC  = 64;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              pwr_ok = 1'b0;
    logic [CODE_W-1:0] cell_code = '0;
    logic              bat_low_n;
    logic              bat_fail_n;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    batt_health_latch #(
        .CODE_W    (CODE_W),
        .LOW_CODE  (LOW_CODE),
        .FAIL_CODE (FAIL_CODE),
        .DELAY_CYC (DELAY_CYC)
    ) u_dut (
        .clk        (clk),
        .rst        (rst),
        .pwr_ok     (pwr_ok),
        .cell_code  (cell_code),
        .bat_low_n  (bat_low_n),
        .bat_fail_n (bat_fail_n)
    );

    task automatic check(input string req, input logic exp_low, input logic exp_fail);
        checks++;
        if (bat_low_n !== exp_low || bat_fail_n !== exp_fail) begin
            fails++;
            $display("FAIL %s: low_n/fail_n = %b%b, expected %b%b",
                     req, bat_low_n, bat_fail_n, exp_low, exp_fail);
        end
    endtask

    // expected verdict from the requirements (R5, R6, R7)
    task automatic expect_for(input int code, output logic el, output logic ef);
        el = (code >= LOW_CODE);
        ef = (code >= FAIL_CODE);
    endtask

    task automatic power_down(input int cycles);
        @(negedge clk); pwr_ok = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R2 drop", 1'b1, 1'b1);
        repeat (cycles) @(posedge clk);
        @(negedge clk);
        check("R2 off", 1'b1, 1'b1);
    endtask

    // power up with code, check R4 window edges, check verdict
    task automatic power_up(input string req, input int code, input int late_code);
        logic el, ef;
        expect_for(code, el, ef);
        @(negedge clk); pwr_ok = 1'b1; cell_code = CODE_W'(code);
        @(posedge clk);                       // sample edge 0
        @(negedge clk); cell_code = CODE_W'(late_code);  // R3 late change
        repeat (DELAY_CYC - 2) @(posedge clk);
        @(posedge clk); @(negedge clk);       // after edge DELAY_CYC-1
        check("R4 hidden", 1'b1, 1'b1);
        @(posedge clk); @(negedge clk);       // after edge DELAY_CYC
        check(req, el, ef);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 in reset", 1'b1, 1'b1);
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 after reset", 1'b1, 1'b1);
    endtask

    task automatic t_levels;
        power_up("R5 healthy", 200, 200);  power_down(2);
        power_up("R5 at LOW_CODE", LOW_CODE, LOW_CODE); power_down(2);
        power_up("R6 weak", 108, 108);     power_down(2);
        power_up("R6 at FAIL_CODE", FAIL_CODE, FAIL_CODE); power_down(2);
        power_up("R7 just below fail", FAIL_CODE - 1, FAIL_CODE - 1); power_down(2);
        power_up("R7 empty", 0, 0);        power_down(2);
    endtask

    task automatic t_late_change;
        // R3: code drops to empty right after the sample edge
        power_up("R3 sample edge code", 180, 5);
        // R8: vary code after reveal, outputs must not move
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); cell_code = CODE_W'(i * 13);
        end
        @(posedge clk); @(negedge clk);
        check("R8 frozen healthy", 1'b1, 1'b1);
        power_down(2);
        power_up("R3 sample edge weak", 110, 250);
        repeat (30) @(posedge clk);
        @(negedge clk);
        check("R8 frozen weak", 1'b0, 1'b1);
        power_down(3);
    endtask

    task automatic t_glitch;
        // dead cell, then a short drop well inside the delay window
        @(negedge clk); pwr_ok = 1'b1; cell_code = 8'd20;
        repeat (10) @(posedge clk);
        @(negedge clk); pwr_ok = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R9 glitch off", 1'b1, 1'b1);
        // comes back with a healthy code: fresh sample, full delay
        power_up("R9 fresh sample", 190, 190);
        power_down(1);
        power_up("R9 new verdict", 60, 60);
        power_down(1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_levels();
        t_late_change();
        t_glitch();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule